// File: doc/BRIEF.md
# Card Configuration Register File

This block holds the host-visible configuration registers of a removable flash memory card. They sit in the card's attribute address space. The host reaches them through a synchronous strobe interface that carries an attribute-space select, an address, a write strobe with a data byte, and a read strobe. The block decodes three fixed register addresses. Two of them are control registers that take writes and read back as zero. The third is a read-only status register that lets software see the control state and the array's ready/busy line.

The two control bits drive the memory array. The soft-reset bit blocks common-memory requests from reaching the array. Register traffic keeps working while this bit is set, so software can clear it again. The power-down bit asks every memory device to enter its low-power state. A card reset pin returns both bits to their default values. While the pin is high it also forces the power-down request.

Top module: `card_cfg_regs`

## Requirements
- R1: After the asynchronous reset `rst_n` is asserted, `soft_rst_o` is 0, `rdata` is 0x00, and `pwr_down_o` follows only `card_rst`.
- R2: A write with `attr_sel`=1 to address 0x4000 loads `wdata[7]` into the soft-reset bit, which appears on `soft_rst_o` after the next rising clock edge (1 = in reset, 0 = out of reset).
- R3: Bits 6..0 of a write to 0x4000 have no effect on either output or on the status register. Reads of 0x4000 and 0x4002 return 0x00.
- R4: A write with `attr_sel`=1 to address 0x4002 loads `wdata[2]` into the power-down bit, which drives `pwr_down_o` high after the next rising edge. All other bits of that write are ignored.
- R5: A read of address 0x4100 returns bit 5 = soft-reset bit, bit 3 = power-down bit, bit 0 = `arr_ready` (1 = ready), and all other bits 0. Bit 0 lags the `arr_ready` pin by SYNC_STAGES clock cycles.
- R6: Writes to 0x4100, writes to any unmapped address, and any write with `attr_sel`=0 change no register state.
- R7: While `card_rst` is 1, `pwr_down_o` is 1 in the same cycle. At each rising edge during `card_rst` both control bits clear, even when a register write is strobed in the same cycle.
- R8: `mem_req_o` equals `mem_req_i` while the soft-reset bit is 0 and is held at 0 while it is 1. Register reads and writes keep working in both states.
- R9: `rdata` is loaded on the rising edge at which `rd_en` and `attr_sel` are both 1. It holds its value at every other edge. A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_rst | input | 1 | Card reset pin, active high, synchronous to clk |
| attr_sel | input | 1 | Access targets attribute space |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| arr_ready | input | 1 | Array ready/busy line, 1 = ready, asynchronous |
| mem_req_i | input | 1 | Common-memory access request from the host |
| mem_req_o | output | 1 | Request passed on to the array |
| soft_rst_o | output | 1 | Soft-reset request to the array |
| pwr_down_o | output | 1 | Power-down request to the array |

## Verification
The assertions assume that the host never strobes `rd_en` and `wr_en` together. They also assume that `card_rst` is a clean level synchronous to the clock. A read and a write in the same cycle would make the status-mirror check compare against a value that is changing. The directed tasks drive every access as a single-cycle strobe on the falling edge and keep reads and writes in separate cycles. They change `arr_ready` only between register accesses and wait out the synchronizer before polling the ready bit.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned BYTE_W = 8;

  // Fixed attribute-space byte offsets.
  localparam int unsigned OPT_OFS  = 32'h4000;
  localparam int unsigned PCTL_OFS = 32'h4002;
  localparam int unsigned STAT_OFS = 32'h4100;

  // Bit positions used by the host software.
  localparam int unsigned OPT_SR_BIT   = 7;
  localparam int unsigned PCTL_PD_BIT  = 2;
  localparam int unsigned STAT_SR_BIT  = 5;
  localparam int unsigned STAT_PD_BIT  = 3;
  localparam int unsigned STAT_RDY_BIT = 0;

  typedef struct packed {
    logic opt;
    logic pctl;
    logic stat;
  } ccr_hit_t;

  function automatic logic [BYTE_W-1:0] stat_byte(input logic sr,
                                                  input logic pd,
                                                  input logic rdy);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[STAT_SR_BIT]  = sr;
    b[STAT_PD_BIT]  = pd;
    b[STAT_RDY_BIT] = rdy;
    return b;
  endfunction

endpackage

// File: rtl/ccr_addr_decode.sv
module ccr_addr_decode
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              attr_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output ccr_hit_t          wr_hit,
  output ccr_hit_t          rd_hit,
  output logic              rd_any
);

  localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_OFS);
  localparam logic [ADDR_W-1:0] PCTL_A = ADDR_W'(PCTL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  ccr_hit_t match;

  always_comb begin
    match.opt  = (addr == OPT_A);
    match.pctl = (addr == PCTL_A);
    match.stat = (addr == STAT_A);
  end

  always_comb begin
    wr_hit = '0;
    rd_hit = '0;
    if (attr_sel && wr_en) begin
      wr_hit.opt  = match.opt;
      wr_hit.pctl = match.pctl;
    end
    if (attr_sel && rd_en) begin
      rd_hit = match;
    end
  end

  assign rd_any = attr_sel & rd_en;

endmodule

// File: rtl/ccr_ctrl_regs.sv
module ccr_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic card_rst,
  input  logic wr_opt,
  input  logic wr_pctl,
  input  logic sr_wbit,
  input  logic pd_wbit,
  output logic sr_q,
  output logic pd_q
);

  logic sr_d, sr_en;
  logic pd_d, pd_en;

  // Next state: card reset pin outranks any write in the same cycle.
  always_comb begin
    sr_en = card_rst | wr_opt;
    pd_en = card_rst | wr_pctl;
    sr_d  = card_rst ? 1'b0 : sr_wbit;
    pd_d  = card_rst ? 1'b0 : pd_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= 1'b0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
    end else if (pd_en) begin
      pd_q <= pd_d;
    end
  end

endmodule

// File: rtl/ccr_rdy_sync.sv
module ccr_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/ccr_read_port.sv
module ccr_read_port
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_any,
  input  ccr_hit_t          rd_hit,
  input  logic              sr_q,
  input  logic              pd_q,
  input  logic              rdy,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] rdata_d;

  // Write-only control registers and unmapped addresses read as zero.
  always_comb begin
    rdata_d = '0;
    if (rd_hit.stat) rdata_d = stat_byte(sr_q, pd_q, rdy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_any) begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/card_cfg_regs.sv
module card_cfg_regs
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_rst,
  input  logic              attr_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              arr_ready,
  input  logic              mem_req_i,
  output logic              mem_req_o,
  output logic              soft_rst_o,
  output logic              pwr_down_o
);

  ccr_hit_t wr_hit, rd_hit;
  logic     rd_any;
  logic     sr_q, pd_q, rdy_s;

  ccr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .attr_sel (attr_sel),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .rd_any   (rd_any)
  );

  ccr_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_rst (card_rst),
    .wr_opt   (wr_hit.opt),
    .wr_pctl  (wr_hit.pctl),
    .sr_wbit  (wdata[OPT_SR_BIT]),
    .pd_wbit  (wdata[PCTL_PD_BIT]),
    .sr_q     (sr_q),
    .pd_q     (pd_q)
  );

  ccr_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (arr_ready),
    .sync_out (rdy_s)
  );

  ccr_read_port u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_any (rd_any),
    .rd_hit (rd_hit),
    .sr_q   (sr_q),
    .pd_q   (pd_q),
    .rdy    (rdy_s),
    .rdata  (rdata)
  );

  assign soft_rst_o = sr_q;
  assign pwr_down_o = pd_q | card_rst;
  assign mem_req_o  = mem_req_i & ~sr_q;

endmodule

// File: rtl/card_cfg_regs_chk.sv
module card_cfg_regs_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              card_rst,
  input logic              attr_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              mem_req_o,
  input logic              soft_rst_o,
  input logic              pwr_down_o
);

  logic wr_opt, wr_pctl, wr_stat, rd_stat;
  assign wr_opt  = attr_sel && wr_en && (addr == ADDR_W'(32'h4000));
  assign wr_pctl = attr_sel && wr_en && (addr == ADDR_W'(32'h4002));
  assign wr_stat = attr_sel && wr_en && (addr == ADDR_W'(32'h4100));
  assign rd_stat = attr_sel && rd_en && (addr == ADDR_W'(32'h4100));

  // R2
  opt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opt && wdata[7] && !card_rst) |=> soft_rst_o);

  // R2
  opt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opt && !wdata[7]) |=> !soft_rst_o);

  // R4
  pctl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pctl && wdata[2] && !card_rst) |=> pwr_down_o);

  // R5
  stat_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_en) |=> (rdata[5] == $past(soft_rst_o)) && (rdata[7:6] == 2'b00)
                            && (rdata[4] == 1'b0) && (rdata[2:1] == 2'b00));

  // R6
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !card_rst) |=> $stable(soft_rst_o));

  // R7
  rst_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> pwr_down_o);

  // R7
  rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> !soft_rst_o);

  // R8
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> !mem_req_o);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && attr_sel) |=> $stable(rdata));

endmodule

bind card_cfg_regs card_cfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .card_rst   (card_rst),
  .attr_sel   (attr_sel),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .mem_req_o  (mem_req_o),
  .soft_rst_o (soft_rst_o),
  .pwr_down_o (pwr_down_o)
);

// File: tb/test_card_cfg_regs.sv
module test_card_cfg_regs;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          card_rst;
  logic          attr_sel;
  logic [AW-1:0] addr;
  logic          wr_en, rd_en;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          arr_ready;
  logic          mem_req_i, mem_req_o;
  logic          soft_rst_o, pwr_down_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cfg_regs #(.ADDR_W(AW), .SYNC_STAGES(2)) i_card_cfg_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_rst   (card_rst),
    .attr_sel   (attr_sel),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .arr_ready  (arr_ready),
    .mem_req_i  (mem_req_i),
    .mem_req_o  (mem_req_o),
    .soft_rst_o (soft_rst_o),
    .pwr_down_o (pwr_down_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    attr_sel = sel; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; attr_sel = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    attr_sel = 1'b1; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; attr_sel = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    chk("R1 soft_rst after reset", soft_rst_o, 0);
    chk("R1 pwr_down after reset", pwr_down_o, 0);
    chk("R1 rdata after reset", rdata, 8'h00);
  endtask

  task automatic t_opt;
    logic [7:0] d;
    wr(1'b1, 16'h4000, 8'h80);
    chk("R2 soft_rst set", soft_rst_o, 1);
    rd(16'h4100, d);
    chk("R5 status sr=1 rdy=1", d, 8'h21);
    wr(1'b1, 16'h4000, 8'h00);
    chk("R2 soft_rst clear", soft_rst_o, 0);
  endtask

  task automatic t_opt_ignored;
    logic [7:0] d;
    wr(1'b1, 16'h4000, 8'h7F);
    chk("R3 low bits no soft_rst", soft_rst_o, 0);
    chk("R3 low bits no pwr_down", pwr_down_o, 0);
    rd(16'h4100, d);
    chk("R3 status unchanged", d, 8'h01);
    wr(1'b1, 16'h4000, 8'hC5);
    rd(16'h4000, d);
    chk("R3 opt reads zero", d, 8'h00);
    rd(16'h4100, d);
    chk("R3 status only bit5", d, 8'h21);
    wr(1'b1, 16'h4000, 8'h00);
  endtask

  task automatic t_pctl;
    logic [7:0] d;
    wr(1'b1, 16'h4002, 8'hFB);
    chk("R4 other bits ignored", pwr_down_o, 0);
    wr(1'b1, 16'h4002, 8'h04);
    chk("R4 pwr_down set", pwr_down_o, 1);
    chk("R4 soft_rst untouched", soft_rst_o, 0);
    rd(16'h4002, d);
    chk("R3 pctl reads zero", d, 8'h00);
    rd(16'h4100, d);
    chk("R5 status pd=1", d, 8'h09);
    wr(1'b1, 16'h4002, 8'h00);
    chk("R4 pwr_down clear", pwr_down_o, 0);
  endtask

  task automatic t_ready;
    logic [7:0] d;
    @(negedge clk) arr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rd(16'h4100, d);
    chk("R5 busy seen", d, 8'h00);
    @(negedge clk) arr_ready = 1'b1;
    // one cycle after change: only first sync stage has it
    @(posedge clk); @(negedge clk);
    attr_sel = 1'b1; addr = 16'h4100; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; attr_sel = 1'b0;
    chk("R5 sync lag", rdata, 8'h00);
    rd(16'h4100, d);
    chk("R5 ready seen", d, 8'h01);
  endtask

  task automatic t_ignored_writes;
    logic [7:0] d;
    wr(1'b1, 16'h4100, 8'hFF);
    chk("R6 status write no sr", soft_rst_o, 0);
    chk("R6 status write no pd", pwr_down_o, 0);
    wr(1'b0, 16'h4000, 8'h80);
    chk("R6 common space write ignored", soft_rst_o, 0);
    wr(1'b0, 16'h4002, 8'h04);
    chk("R6 common space pctl ignored", pwr_down_o, 0);
    wr(1'b1, 16'h4001, 8'h80);
    wr(1'b1, 16'h0002, 8'h04);
    rd(16'h4100, d);
    chk("R6 unmapped writes ignored", d, 8'h01);
    rd(16'h1234, d);
    chk("R9 unmapped read zero", d, 8'h00);
  endtask

  task automatic t_card_rst;
    wr(1'b1, 16'h4000, 8'h80);
    wr(1'b1, 16'h4002, 8'h00);
    @(negedge clk) card_rst = 1'b1;
    #1;
    chk("R7 pwr_down immediate", pwr_down_o, 1);
    chk("R7 soft_rst held before edge", soft_rst_o, 1);
    @(negedge clk);
    chk("R7 soft_rst cleared", soft_rst_o, 0);
    attr_sel = 1'b1; addr = 16'h4000; wdata = 8'h80; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; attr_sel = 1'b0;
    chk("R7 pin beats write", soft_rst_o, 0);
    card_rst = 1'b0;
    #1;
    chk("R7 pwr_down released", pwr_down_o, 0);
    wr(1'b1, 16'h4002, 8'h04);
    @(negedge clk) card_rst = 1'b1;
    @(negedge clk) card_rst = 1'b0;
    #1;
    chk("R7 pd bit cleared by pin", pwr_down_o, 0);
  endtask

  task automatic t_mem_block;
    logic [7:0] d;
    @(negedge clk) mem_req_i = 1'b1;
    #1;
    chk("R8 pass when not in reset", mem_req_o, 1);
    wr(1'b1, 16'h4000, 8'h80);
    chk("R8 blocked in soft reset", mem_req_o, 0);
    rd(16'h4100, d);
    chk("R8 status readable in soft reset", d, 8'h21);
    wr(1'b1, 16'h4000, 8'h00);
    chk("R8 pass after clear", mem_req_o, 1);
    @(negedge clk) mem_req_i = 1'b0;
    #1;
    chk("R8 follows input low", mem_req_o, 0);
  endtask

  task automatic t_read_hold;
    logic [7:0] d;
    wr(1'b1, 16'h4000, 8'h80);
    rd(16'h4100, d);
    wr(1'b1, 16'h4000, 8'h00);
    @(negedge clk);
    attr_sel = 1'b0; addr = 16'h4100; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 rdata holds without attr_sel", rdata, 8'h21);
    repeat (2) @(negedge clk);
    chk("R9 rdata holds when idle", rdata, 8'h21);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; card_rst = 1'b0; attr_sel = 1'b0; addr = '0;
    wr_en = 1'b0; rd_en = 1'b0; wdata = '0; arr_ready = 1'b1; mem_req_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_opt();
    t_opt_ignored();
    t_pctl();
    t_ready();
    t_ignored_writes();
    t_card_rst();
    t_mem_block();
    t_read_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule